// File: doc/BRIEF.md
# Interrupt acknowledge and completion unit

This unit sits between the CPU interfaces of an interrupt controller and its pending and active state. When a CPU reads its acknowledge register, the unit returns the interrupt currently selected for that CPU. For a software-generated interrupt, the returned word also names the CPU that raised it. The unit then moves that interrupt from pending to active, clears the CPU's selection and drops the CPU's IRQ line. When a CPU writes an end-of-interrupt word in the same format, the matching active bit is cleared. A write naming an interrupt that is not active sets a sticky error flag.

The unit holds two stores. Software interrupts (ids 0 to 15) are tracked per (id, source CPU, destination CPU) triple, for both pending and active. Shared interrupts (ids 16 up to `NUM_IRQ-1`) have one pending bit and one active bit each. An external arbiter loads each CPU's selected id. The unit reports every CPU's running priority, computed from the active state and a priority table supplied at its input. The acknowledge path is a two-state machine. `ST_IDLE` moves to `ST_RESP` on a request. `ST_RESP` drives the response valid. From `ST_RESP` the machine stays in `ST_RESP` on a back-to-back request and returns to `ST_IDLE` otherwise.

Top module: `irq_ack_unit`

## Requirements
- R1: Acknowledge words carry the interrupt id in bits [9:0] and the source CPU in bits [12:10]. The source field is 0 for ids of 16 and above. `ack_rvalid` is high, with the word on `ack_data`, exactly in the cycle after `ack_req`.
- R2: When `dist_en` is low or the reading CPU's `cpu_en` bit is low, the acknowledge returns 1023. Pending state, active state, the selection and the IRQ line all stay unchanged.
- R3: Acknowledging a software id reports the lowest-numbered source CPU whose pending bit for the reading CPU is set. That pending bit is cleared and the active bit for the same (source, destination) pair is set.
- R4: Acknowledging a shared id (16 to `NUM_IRQ-1`) sets its active bit and clears its pending bit.
- R5: After an enabled acknowledge, the CPU's selection becomes 1023, so the next acknowledge returns 1023. Its `irq` bit goes low.
- R6: An end-of-interrupt write (id in bits [9:0], source in [12:10]) clears the matching software active pair or shared active bit.
- R7: An end-of-interrupt write naming an interrupt that is not active sets `eoi_err`. The flag stays set until an `err_clr` pulse. A new error in the same cycle as the pulse wins.
- R8: Each CPU's `run_prio` is the smallest priority value among the interrupts active for it, or 0xFF when none are. A software pair counts only for its destination CPU. A shared active id counts for every CPU.
- R9: A software raise sets the pending bit of id `sgi_id` from `sgi_src` for every CPU in `sgi_dst`. This shows on `cpu_sgi_pend` bit c*16+id. A shared set with an id below 16 is ignored.
- R10: After reset, `irq`, `spi_pend`, `cpu_sgi_pend`, `eoi_err` and `ack_rvalid` are zero, every `run_prio` is 0xFF, and every selection is 1023.
- R11: A `sel_load` pulse stores the new selection. It raises that CPU's `irq` when the id is not 1023 and lowers it otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dist_en | input | 1 | Global distributor enable |
| cpu_en | input | NUM_CPU | Per-CPU interface enable |
| sel_load | input | NUM_CPU | Arbiter strobe loading a CPU's selected id |
| sel_id_in | input | NUM_CPU*10 | Selected id per CPU, 10 bits each |
| irq | output | NUM_CPU | IRQ line per CPU |
| sgi_raise | input | 1 | Software interrupt raise strobe |
| sgi_src | input | CPU_W | Raising CPU |
| sgi_id | input | 4 | Software interrupt id |
| sgi_dst | input | NUM_CPU | Destination CPU mask |
| spi_set | input | 1 | Shared interrupt pending set strobe |
| spi_id | input | 10 | Shared interrupt id |
| prio_flat | input | NUM_IRQ*8 | Priority per id, 8 bits each |
| ack_req | input | 1 | Acknowledge read request |
| ack_cpu | input | CPU_W | Reading CPU |
| ack_rvalid | output | 1 | Acknowledge response valid |
| ack_data | output | 13 | Acknowledge word |
| eoi_req | input | 1 | End-of-interrupt write strobe |
| eoi_cpu | input | CPU_W | Writing CPU |
| eoi_word | input | 13 | End-of-interrupt word |
| eoi_err | output | 1 | Sticky completion error |
| err_clr | input | 1 | Write-one-to-clear for `eoi_err` |
| run_prio | output | NUM_CPU*8 | Running priority per CPU |
| spi_pend | output | NUM_IRQ | Shared pending bits |
| cpu_sgi_pend | output | NUM_CPU*16 | Software pending summary per CPU and id |

## Verification
The bench raises one software id from two sources toward the same CPU. It expects the lower source first and the higher source on the second acknowledge. A design that scanned from the top, or cleared the whole id, would return the wrong source field or lose the second event. It completes each pair separately and checks that the running priority holds until the last pair ends. It then repeats a completion to provoke the sticky error. It also acknowledges with the distributor or the CPU interface off, and checks that the IRQ line and the shared pending bit survive. A design that updated state before testing the enables would drop the interrupt silently.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
    localparam int ID_W   = 10;
    localparam int SRC_W  = 3;
    localparam int WORD_W = ID_W + SRC_W;
    localparam int SGI_N  = 16;
    localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } ack_state_e;
endpackage

// File: rtl/irq_min_prio.sv
module irq_min_prio #(
    parameter int N  = 64,
    parameter int PW = 8
) (
    input  logic [N-1:0]    act,
    input  logic [N*PW-1:0] prio_flat,
    output logic [PW-1:0]   min_prio
);
    always_comb begin
        min_prio = '1;
        for (int i = 0; i < N; i++) begin
            if (act[i] && (prio_flat[i*PW +: PW] < min_prio))
                min_prio = prio_flat[i*PW +: PW];
        end
    end
endmodule

// File: rtl/irq_src_pick.sv
module irq_src_pick #(
    parameter int N = 4,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    // walk downward so the lowest requesting source is the last one written
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_ack_unit.sv
module irq_ack_unit
    import irq_ack_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int NUM_IRQ = 64,
    parameter int PRIO_W  = 8,
    localparam int CPU_W  = $clog2(NUM_CPU),
    localparam int IRQ_W  = $clog2(NUM_IRQ)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      dist_en,
    input  logic [NUM_CPU-1:0]        cpu_en,
    input  logic [NUM_CPU-1:0]        sel_load,
    input  logic [NUM_CPU*ID_W-1:0]   sel_id_in,
    output logic [NUM_CPU-1:0]        irq,
    input  logic                      sgi_raise,
    input  logic [CPU_W-1:0]          sgi_src,
    input  logic [3:0]                sgi_id,
    input  logic [NUM_CPU-1:0]        sgi_dst,
    input  logic                      spi_set,
    input  logic [ID_W-1:0]           spi_id,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio_flat,
    input  logic                      ack_req,
    input  logic [CPU_W-1:0]          ack_cpu,
    output logic                      ack_rvalid,
    output logic [WORD_W-1:0]         ack_data,
    input  logic                      eoi_req,
    input  logic [CPU_W-1:0]          eoi_cpu,
    input  logic [WORD_W-1:0]         eoi_word,
    output logic                      eoi_err,
    input  logic                      err_clr,
    output logic [NUM_CPU*PRIO_W-1:0] run_prio,
    output logic [NUM_IRQ-1:0]        spi_pend,
    output logic [NUM_CPU*SGI_N-1:0]  cpu_sgi_pend
);
    localparam logic [ID_W-1:0] SGI_LIM = ID_W'(SGI_N);
    localparam logic [ID_W-1:0] IRQ_LIM = ID_W'(NUM_IRQ);
    localparam logic [SRC_W:0]  CPU_LIM = (SRC_W+1)'(NUM_CPU);

    // software stores indexed [id][source][destination]
    logic [SGI_N-1:0][NUM_CPU-1:0][NUM_CPU-1:0] sgi_pend_q, sgi_pend_d;
    logic [SGI_N-1:0][NUM_CPU-1:0][NUM_CPU-1:0] sgi_act_q,  sgi_act_d;
    logic [NUM_IRQ-1:0] spi_pend_q, spi_pend_d, spi_act_q, spi_act_d;
    logic [NUM_CPU-1:0][ID_W-1:0] sel_q, sel_d;
    logic [NUM_CPU-1:0] irq_q, irq_d;
    logic               err_q, err_d;
    logic [WORD_W-1:0]  data_q, ack_word;
    ack_state_e         state_q, state_d;

    // acknowledge decode
    logic [ID_W-1:0]    cur_id;
    logic               ack_ok, cur_sgi, cur_spi, src_found;
    logic [NUM_CPU-1:0] src_req;
    logic [CPU_W-1:0]   src_idx;

    assign ack_ok  = dist_en && cpu_en[ack_cpu];
    assign cur_id  = sel_q[ack_cpu];
    assign cur_sgi = cur_id < SGI_LIM;
    assign cur_spi = !cur_sgi && (cur_id < IRQ_LIM);

    always_comb begin
        for (int s = 0; s < NUM_CPU; s++)
            src_req[s] = sgi_pend_q[cur_id[3:0]][s][ack_cpu];
    end

    irq_src_pick #(.N(NUM_CPU)) u_pick (
        .req   (src_req),
        .found (src_found),
        .idx   (src_idx)
    );

    always_comb begin
        ack_word = {{SRC_W{1'b0}}, SPURIOUS_ID};
        if (ack_ok)
            ack_word = {(cur_sgi && src_found) ? SRC_W'(src_idx) : {SRC_W{1'b0}}, cur_id};
    end

    // completion decode
    logic [ID_W-1:0]  eoi_id;
    logic [CPU_W-1:0] eoi_src;
    logic             eoi_src_ok, eoi_bad;

    assign eoi_id     = eoi_word[ID_W-1:0];
    assign eoi_src    = eoi_word[ID_W +: CPU_W];
    assign eoi_src_ok = {1'b0, eoi_word[WORD_W-1:ID_W]} < CPU_LIM;

    // next-state of stores, selections and error flag
    always_comb begin
        sgi_pend_d = sgi_pend_q;
        sgi_act_d  = sgi_act_q;
        spi_pend_d = spi_pend_q;
        spi_act_d  = spi_act_q;
        sel_d      = sel_q;
        irq_d      = irq_q;
        eoi_bad    = 1'b0;

        if (spi_set && (spi_id >= SGI_LIM) && (spi_id < IRQ_LIM))
            spi_pend_d[spi_id[IRQ_W-1:0]] = 1'b1;

        if (sgi_raise) begin
            for (int d = 0; d < NUM_CPU; d++)
                if (sgi_dst[d]) sgi_pend_d[sgi_id][sgi_src][d] = 1'b1;
        end

        if (eoi_req) begin
            if (eoi_id < SGI_LIM) begin
                if (eoi_src_ok && sgi_act_q[eoi_id[3:0]][eoi_src][eoi_cpu])
                    sgi_act_d[eoi_id[3:0]][eoi_src][eoi_cpu] = 1'b0;
                else
                    eoi_bad = 1'b1;
            end else if (eoi_id < IRQ_LIM) begin
                if (spi_act_q[eoi_id[IRQ_W-1:0]])
                    spi_act_d[eoi_id[IRQ_W-1:0]] = 1'b0;
                else
                    eoi_bad = 1'b1;
            end else begin
                eoi_bad = 1'b1;
            end
        end

        if (ack_req && ack_ok) begin
            if (cur_sgi && src_found) begin
                sgi_pend_d[cur_id[3:0]][src_idx][ack_cpu] = 1'b0;
                sgi_act_d[cur_id[3:0]][src_idx][ack_cpu]  = 1'b1;
            end else if (cur_spi) begin
                spi_act_d[cur_id[IRQ_W-1:0]]  = 1'b1;
                spi_pend_d[cur_id[IRQ_W-1:0]] = 1'b0;
            end
            sel_d[ack_cpu] = SPURIOUS_ID;
            irq_d[ack_cpu] = 1'b0;
        end

        for (int c = 0; c < NUM_CPU; c++) begin
            if (sel_load[c]) begin
                sel_d[c] = sel_id_in[c*ID_W +: ID_W];
                irq_d[c] = sel_id_in[c*ID_W +: ID_W] != SPURIOUS_ID;
            end
        end

        err_d = eoi_bad || (err_q && !err_clr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sgi_pend_q <= '0;
            sgi_act_q  <= '0;
            spi_pend_q <= '0;
            spi_act_q  <= '0;
            sel_q      <= {NUM_CPU{SPURIOUS_ID}};
            irq_q      <= '0;
            err_q      <= 1'b0;
            data_q     <= '0;
        end else begin
            sgi_pend_q <= sgi_pend_d;
            sgi_act_q  <= sgi_act_d;
            spi_pend_q <= spi_pend_d;
            spi_act_q  <= spi_act_d;
            sel_q      <= sel_d;
            irq_q      <= irq_d;
            err_q      <= err_d;
            if (ack_req) data_q <= ack_word;
        end
    end

    // response state machine
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE: state_d = ack_req ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = ack_req ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ack_rvalid = 1'b0;
        unique case (state_q)
            ST_IDLE: ack_rvalid = 1'b0;
            ST_RESP: ack_rvalid = 1'b1;
            default: ack_rvalid = 1'b0;
        endcase
    end

    assign ack_data = data_q;
    assign irq      = irq_q;
    assign eoi_err  = err_q;
    assign spi_pend = spi_pend_q;

    // per-CPU running priority and pending summary
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        logic [NUM_IRQ-1:0] act_mask;
        logic [SGI_N-1:0]   pend_any;

        always_comb begin
            act_mask = spi_act_q;
            act_mask[SGI_N-1:0] = '0;
            pend_any = '0;
            for (int i = 0; i < SGI_N; i++) begin
                for (int s = 0; s < NUM_CPU; s++) begin
                    if (sgi_act_q[i][s][c])  act_mask[i] = 1'b1;
                    if (sgi_pend_q[i][s][c]) pend_any[i] = 1'b1;
                end
            end
        end

        irq_min_prio #(.N(NUM_IRQ), .PW(PRIO_W)) u_min (
            .act       (act_mask),
            .prio_flat (prio_flat),
            .min_prio  (run_prio[c*PRIO_W +: PRIO_W])
        );

        assign cpu_sgi_pend[c*SGI_N +: SGI_N] = pend_any;
    end
endmodule

// File: rtl/irq_ack_unit_chk.sv
module irq_ack_unit_chk
    import irq_ack_pkg::*;
#(
    parameter int NUM_CPU = 4,
    localparam int CPU_W  = $clog2(NUM_CPU)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               dist_en,
    input logic [NUM_CPU-1:0] cpu_en,
    input logic [NUM_CPU-1:0] sel_load,
    input logic [NUM_CPU-1:0] irq,
    input logic               ack_req,
    input logic [CPU_W-1:0]   ack_cpu,
    input logic               ack_rvalid,
    input logic [WORD_W-1:0]  ack_data,
    input logic               eoi_err,
    input logic               err_clr
);
    assert_resp_next_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |=> ack_rvalid);

    assert_resp_only_after_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ack_rvalid |-> $past(ack_req));

    assert_shared_src_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rvalid && (ack_data[ID_W-1:0] >= 10'd16)) |-> (ack_data[WORD_W-1:ID_W] == 3'd0));

    assert_disabled_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && !(dist_en && cpu_en[ack_cpu])) |=> (ack_data[ID_W-1:0] == SPURIOUS_ID));

    assert_irq_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && dist_en && cpu_en[ack_cpu] && !sel_load[ack_cpu]) |=> !irq[$past(ack_cpu)]);

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_err && !err_clr) |=> eoi_err);
endmodule

bind irq_ack_unit irq_ack_unit_chk #(.NUM_CPU(NUM_CPU)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dist_en    (dist_en),
    .cpu_en     (cpu_en),
    .sel_load   (sel_load),
    .irq        (irq),
    .ack_req    (ack_req),
    .ack_cpu    (ack_cpu),
    .ack_rvalid (ack_rvalid),
    .ack_data   (ack_data),
    .eoi_err    (eoi_err),
    .err_clr    (err_clr)
);

// File: tb/irq_ack_unit_test.sv
module irq_ack_unit_test;
    localparam int NC = 4;
    localparam int NI = 64;
    localparam int CW = 2;

    localparam logic [2:0] OP_RAISE = 3'd0, OP_SPI = 3'd1, OP_LOAD = 3'd2, OP_ACK = 3'd3;
    localparam logic [2:0] OP_EOI = 3'd4, OP_PRIO = 3'd5, OP_SGIP = 3'd6, OP_SPIP = 3'd7;
    localparam int NV = 37;
    // {op, cpu, arg, expected}; raise arg: [3:0] id, [11:8] destination mask
    localparam logic [37:0] VEC [NV] = '{
        {OP_RAISE, 3'd2, 16'h0305, 16'h0000},
        {OP_RAISE, 3'd1, 16'h0105, 16'h0000},
        {OP_SGIP,  3'd0, 16'h0000, 16'h0020},
        {OP_LOAD,  3'd0, 16'd5,    16'h0001},
        {OP_ACK,   3'd0, 16'h0000, 16'h0405},
        {OP_PRIO,  3'd0, 16'h0000, 16'h00B9},
        {OP_PRIO,  3'd1, 16'h0000, 16'h00FF},
        {OP_SGIP,  3'd0, 16'h0000, 16'h0020},
        {OP_ACK,   3'd0, 16'h0000, 16'h03FF},
        {OP_LOAD,  3'd0, 16'd5,    16'h0001},
        {OP_ACK,   3'd0, 16'h0000, 16'h0805},
        {OP_SGIP,  3'd0, 16'h0000, 16'h0000},
        {OP_SGIP,  3'd1, 16'h0000, 16'h0020},
        {OP_EOI,   3'd0, 16'h0405, 16'h0000},
        {OP_PRIO,  3'd0, 16'h0000, 16'h00B9},
        {OP_EOI,   3'd0, 16'h0805, 16'h0000},
        {OP_PRIO,  3'd0, 16'h0000, 16'h00FF},
        {OP_EOI,   3'd0, 16'h0805, 16'h0001},
        {OP_SPI,   3'd0, 16'd20,   16'h0000},
        {OP_SPI,   3'd0, 16'd3,    16'h0000},
        {OP_SPIP,  3'd0, 16'd0,    16'h0000},
        {OP_SPIP,  3'd0, 16'd16,   16'h0010},
        {OP_LOAD,  3'd1, 16'd20,   16'h0001},
        {OP_ACK,   3'd1, 16'h0000, 16'h0014},
        {OP_SPIP,  3'd0, 16'd16,   16'h0000},
        {OP_PRIO,  3'd1, 16'h0000, 16'h008C},
        {OP_PRIO,  3'd0, 16'h0000, 16'h008C},
        {OP_SPI,   3'd0, 16'd40,   16'h0000},
        {OP_LOAD,  3'd2, 16'd40,   16'h0001},
        {OP_ACK,   3'd2, 16'h0000, 16'h0028},
        {OP_PRIO,  3'd2, 16'h0000, 16'h0050},
        {OP_EOI,   3'd1, 16'h0014, 16'h0000},
        {OP_PRIO,  3'd1, 16'h0000, 16'h0050},
        {OP_EOI,   3'd2, 16'h0028, 16'h0000},
        {OP_PRIO,  3'd2, 16'h0000, 16'h00FF},
        {OP_EOI,   3'd3, 16'h0005, 16'h0001},
        {OP_LOAD,  3'd3, 16'd1023, 16'h0000}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dist_en = 1'b1;
    logic [NC-1:0] cpu_en = '1;
    logic [NC-1:0] sel_load = '0;
    logic [NC*10-1:0] sel_id_in = '0;
    logic [NC-1:0] irq;
    logic sgi_raise = 1'b0;
    logic [CW-1:0] sgi_src = '0;
    logic [3:0] sgi_id = '0;
    logic [NC-1:0] sgi_dst = '0;
    logic spi_set = 1'b0;
    logic [9:0] spi_id = '0;
    logic [NI*8-1:0] prio_flat;
    logic ack_req = 1'b0;
    logic [CW-1:0] ack_cpu = '0;
    logic ack_rvalid;
    logic [12:0] ack_data;
    logic eoi_req = 1'b0;
    logic [CW-1:0] eoi_cpu = '0;
    logic [12:0] eoi_word = '0;
    logic eoi_err;
    logic err_clr = 1'b0;
    logic [NC*8-1:0] run_prio;
    logic [NI-1:0] spi_pend;
    logic [NC*16-1:0] cpu_sgi_pend;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    // priority of id i is 200 - 3*i
    always_comb begin
        for (int i = 0; i < NI; i++) prio_flat[i*8 +: 8] = 8'(200 - 3 * i);
    end

    irq_ack_unit #(.NUM_CPU(NC), .NUM_IRQ(NI), .PRIO_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .dist_en(dist_en), .cpu_en(cpu_en),
        .sel_load(sel_load), .sel_id_in(sel_id_in), .irq(irq),
        .sgi_raise(sgi_raise), .sgi_src(sgi_src), .sgi_id(sgi_id), .sgi_dst(sgi_dst),
        .spi_set(spi_set), .spi_id(spi_id), .prio_flat(prio_flat),
        .ack_req(ack_req), .ack_cpu(ack_cpu), .ack_rvalid(ack_rvalid), .ack_data(ack_data),
        .eoi_req(eoi_req), .eoi_cpu(eoi_cpu), .eoi_word(eoi_word), .eoi_err(eoi_err),
        .err_clr(err_clr), .run_prio(run_prio), .spi_pend(spi_pend), .cpu_sgi_pend(cpu_sgi_pend)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_ack(input int c, output logic [12:0] d, output logic v);
        @(negedge clk);
        ack_req = 1'b1; ack_cpu = CW'(c);
        @(negedge clk);
        ack_req = 1'b0;
        v = ack_rvalid; d = ack_data;
    endtask

    task automatic do_eoi(input int c, input logic [12:0] w);
        @(negedge clk);
        eoi_req = 1'b1; eoi_cpu = CW'(c); eoi_word = w;
        @(negedge clk);
        eoi_req = 1'b0;
    endtask

    task automatic do_load(input int c, input logic [9:0] id);
        @(negedge clk);
        sel_load[c] = 1'b1; sel_id_in[c*10 +: 10] = id;
        @(negedge clk);
        sel_load = '0;
    endtask

    task automatic do_spi(input logic [9:0] id);
        @(negedge clk);
        spi_set = 1'b1; spi_id = id;
        @(negedge clk);
        spi_set = 1'b0;
    endtask

    task automatic do_clr();
        @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [12:0] d;
        logic v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        check(irq == '0, "R10 irq", int'(irq), 0);
        check(!ack_rvalid && !eoi_err, "R10 rvalid/err", int'({ack_rvalid, eoi_err}), 0);
        check(run_prio == {NC{8'hFF}}, "R10 run_prio", int'(run_prio), 32'hFFFFFFFF);
        check(spi_pend == '0 && cpu_sgi_pend == '0, "R10 pending", int'(spi_pend[31:0]), 0);

        for (int k = 0; k < NV; k++) begin
            automatic logic [2:0]  op  = VEC[k][37:35];
            automatic int          cp  = int'(VEC[k][34:32]);
            automatic logic [15:0] arg = VEC[k][31:16];
            automatic logic [15:0] ex  = VEC[k][15:0];
            unique case (op)
                OP_RAISE: begin
                    @(negedge clk);
                    sgi_raise = 1'b1; sgi_src = CW'(cp); sgi_id = arg[3:0]; sgi_dst = arg[11:8];
                    @(negedge clk);
                    sgi_raise = 1'b0;
                end
                OP_SPI: do_spi(arg[9:0]);
                OP_LOAD: begin
                    do_load(cp, arg[9:0]);
                    check(irq[cp] == ex[0], "R11 irq after load", int'(irq[cp]), int'(ex[0]));
                end
                OP_ACK: begin
                    do_ack(cp, d, v);
                    check(v, "R1 rvalid", int'(v), 1);
                    check(d == ex[12:0], "R1/R3/R4/R5 ack word", int'(d), int'(ex));
                end
                OP_EOI: begin
                    do_eoi(cp, arg[12:0]);
                    check(eoi_err == ex[0], "R6/R7 eoi error", int'(eoi_err), int'(ex[0]));
                    if (ex[0]) do_clr();
                end
                OP_PRIO: check(run_prio[cp*8 +: 8] == ex[7:0], "R8 run_prio",
                               int'(run_prio[cp*8 +: 8]), int'(ex));
                OP_SGIP: check(cpu_sgi_pend[cp*16 +: 16] == ex, "R3/R9 sgi pending",
                               int'(cpu_sgi_pend[cp*16 +: 16]), int'(ex));
                OP_SPIP: check(spi_pend[int'(arg) +: 16] == ex, "R4/R9 shared pending",
                               int'(spi_pend[int'(arg) +: 16]), int'(ex));
                default: ;
            endcase
        end

        // R2: disabled acknowledges change nothing
        do_spi(10'd50);
        do_load(3, 10'd50);
        dist_en = 1'b0;
        do_ack(3, d, v);
        check(d == 13'h3FF, "R2 dist off word", int'(d), 32'h3FF);
        check(irq[3] == 1'b1, "R2 irq kept", int'(irq[3]), 1);
        check(spi_pend[50] == 1'b1, "R2 pending kept", int'(spi_pend[50]), 1);
        dist_en = 1'b1; cpu_en[3] = 1'b0;
        do_ack(3, d, v);
        check(d == 13'h3FF, "R2 cpu off word", int'(d), 32'h3FF);
        check(run_prio[24 +: 8] == 8'hFF, "R2 nothing active", int'(run_prio[24 +: 8]), 32'hFF);
        cpu_en[3] = 1'b1;
        do_ack(3, d, v);
        check(d == 13'h0032, "R4 ack after enable", int'(d), 32'h32);
        check(irq[3] == 1'b0, "R5 irq dropped", int'(irq[3]), 0);
        check(spi_pend[50] == 1'b0, "R4 pending cleared", int'(spi_pend[50]), 0);

        // R7: sticky error and write-one-to-clear
        do_eoi(0, 13'h0030);
        check(eoi_err == 1'b1, "R7 error set", int'(eoi_err), 1);
        repeat (3) @(negedge clk);
        check(eoi_err == 1'b1, "R7 error held", int'(eoi_err), 1);
        do_clr();
        check(eoi_err == 1'b0, "R7 error cleared", int'(eoi_err), 0);
        do_eoi(3, 13'h0032);
        check(eoi_err == 1'b0, "R6 shared eoi ok", int'(eoi_err), 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule